// File: doc/BRIEF.md
# Shared-Bus Agent Request Gating

This block sits in the bus interface of one symmetric agent on a processor bus shared by two symmetric agents and one priority agent. It decides in which cycle the local agent may start a new transaction. When reset is released it takes its agent number from the bus request lines. It drives its own request line while local work is pending. It tracks which of the two symmetric agents owns the bus, using a rotating rule, and offers a valid/ready issue handshake to the local transaction logic.

New issues are withheld in three cases. The first is while the priority agent holds its request, unless the agent is inside a locked sequence. The second is while the shared stall line is seen asserted. The stall line is the wired-OR of every agent's stall output, and the block samples it only on a fixed sampling phase. The third is whenever the agent is not the owner.

A bus-initialization event, when observation of it is enabled, clears the lock state and the arbitration state. Pending local work is kept, so the agent arbitrates again and then goes on issuing it.

All bus-side controls are active low. The block registers each bus-side input once before using it.

Top module: `bus_agent_gate`

## Requirements
- R1: On the first clock edge after `rst_n` rises, `agent_id_o` takes the index of the asserted (low) request line in `req_n_i`. Line 0 wins if both are low, and the value is 0 if neither is low. The value then holds until the next reset.
- R2: `req_n_o` is driven low in the cycle after a clock edge that samples `txn_valid_i` high, and high in the cycle after an edge that samples it low. It is also high while the agent number is not yet latched.
- R3: Ownership goes to agent 0 when the agent number is latched. An owner gives the bus to the other symmetric agent if that agent's registered request is asserted and the owner either issues in that cycle or has its own request deasserted. A non-owner with its request raised takes the bus if the other agent's registered request is deasserted, or if a registered peer-issue strobe (`peer_issue_n_i` low) is seen. The current owner is shown on `bus_own_o`.
- R4: `txn_ready_o` is high only while `bus_own_o` is high and neither the priority gate nor the stall gate blocks. A transfer happens when `txn_valid_i` and `txn_ready_o` are both high.
- R5: If `prio_n_i` is sampled low at a clock edge and the lock flag is clear, `txn_ready_o` is low from that edge. When `prio_n_i` is sampled high again, the priority block ends at that edge.
- R6: A `lock_start_i` pulse sets the lock flag at the next edge, and a `lock_end_i` pulse clears it. If both are high together, the clear wins. While the flag is set, the priority request does not gate `txn_ready_o`.
- R7: The registered stall input is taken into the stall gate once every `STALL_PERIOD` cycles and held in between. So a change on `stall_n_i` reaches `txn_ready_o` within `STALL_PERIOD`+1 cycles, and a held stall keeps `txn_ready_o` low.
- R8: If `init_obs_en_i` is high and a registered `init_n_i` low is seen, then at the next edge the lock flag clears, ownership returns to agent 0 and `req_n_o` goes high for one cycle. This init clear takes priority over a `lock_start_i` pulse in the same cycle. If `txn_valid_i` stays high, the agent then arbitrates again and issues.
- R9: If `init_obs_en_i` is low, an asserted `init_n_i` changes neither the lock flag, the ownership nor `req_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; its release marks the agent-number sample |
| req_n_i | input | 2 | Observed bus request lines of the two symmetric agents, active low |
| req_n_o | output | 1 | This agent's bus request, active low |
| prio_n_i | input | 1 | Priority agent request, active low |
| stall_n_i | input | 1 | Wired-OR stall line, active low |
| init_n_i | input | 1 | Bus-initialization event, active low |
| peer_issue_n_i | input | 1 | Strobe marking a transaction started by the other symmetric agent, active low |
| init_obs_en_i | input | 1 | Configuration: 1 enables the response to bus-init |
| lock_start_i | input | 1 | Pulse that starts a locked sequence |
| lock_end_i | input | 1 | Pulse that ends a locked sequence |
| txn_valid_i | input | 1 | Local transaction pending |
| txn_ready_o | output | 1 | Issue permitted in this cycle |
| bus_own_o | output | 1 | This agent currently owns the bus |
| agent_id_o | output | 1 | Agent number latched at reset release |

## Verification
Two functions can act on the lock flag in the same cycle: the bus-init clear and the local lock-start pulse. The bench provokes this by pulsing `init_n_i` and then raising `lock_start_i` exactly one cycle later, so that both reach the lock logic at the same edge. The outcome is judged at the ports. The priority request is held asserted, and `txn_ready_o` must stay low once ownership has come back, which shows that the lock exemption is gone. A second such pair is a local issue and a rising peer request arriving together; the bench checks that ownership moves to the peer.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int unsigned NAG = 2;
  typedef logic [0:0] agent_id_t;

  // agent number from active-low request lines; line 0 has precedence
  function automatic agent_id_t f_id_from_lines(input logic [NAG-1:0] lines_n);
    if (!lines_n[0]) return agent_id_t'(0);
    if (!lines_n[1]) return agent_id_t'(1);
    return agent_id_t'(0);
  endfunction

  // issue permission from the gating terms
  function automatic logic f_may_issue(input logic own, input logic prio,
                                       input logic lock, input logic stall);
    return own & ~(prio & ~lock) & ~stall;
  endfunction
endpackage

// File: rtl/bag_sync.sv
module bag_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_n,
  output logic [W-1:0] q
);
  // one register stage per bus input, output active high
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= 1'b0;
      else        q[g] <= ~d_n[g];
    end
  end
endmodule

// File: rtl/bag_stall_sampler.sv
module bag_stall_sampler #(
  parameter int unsigned STALL_PERIOD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall_s,
  output logic stall_hold,
  output logic phase_hit
);
  localparam int unsigned PW = (STALL_PERIOD > 1) ? $clog2(STALL_PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(STALL_PERIOD - 1);

  logic [PW-1:0] phase_q;

  assign phase_hit = (phase_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= '0;
      stall_hold <= 1'b0;
    end else begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      if (phase_hit) stall_hold <= stall_s;
    end
  end
endmodule

// File: rtl/bag_arbiter.sv
module bag_arbiter
  import bag_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NAG-1:0] req_lines_n,
  input  logic [NAG-1:0] req_s,
  input  logic           pending,
  input  logic           fire,
  input  logic           peer_issue_s,
  input  logic           init_evt,
  output agent_id_t      agent_id,
  output logic           id_valid,
  output logic           own,
  output logic           req_q
);
  agent_id_t peer_id;
  logic      peer_req;
  logic      give_up;
  logic      take_over;
  agent_id_t sampled_id;

  assign peer_id    = ~agent_id;
  assign peer_req   = req_s[peer_id];
  assign sampled_id = f_id_from_lines(req_lines_n);
  assign give_up    = peer_req & (fire | ~req_q);
  assign take_over  = req_q & (~peer_req | peer_issue_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_valid <= 1'b0;
      agent_id <= '0;
      own      <= 1'b0;
      req_q    <= 1'b0;
    end else if (!id_valid) begin
      id_valid <= 1'b1;
      agent_id <= sampled_id;
      own      <= (sampled_id == agent_id_t'(0));
      req_q    <= 1'b0;
    end else if (init_evt) begin
      own   <= (agent_id == agent_id_t'(0));
      req_q <= 1'b0;
    end else begin
      req_q <= pending;
      own   <= own ? ~give_up : take_over;
    end
  end
endmodule

// File: rtl/bus_agent_gate.sv
module bus_agent_gate
  import bag_pkg::*;
#(
  parameter int unsigned STALL_PERIOD = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NAG-1:0] req_n_i,
  output logic           req_n_o,
  input  logic           prio_n_i,
  input  logic           stall_n_i,
  input  logic           init_n_i,
  input  logic           peer_issue_n_i,
  input  logic           init_obs_en_i,
  input  logic           lock_start_i,
  input  logic           lock_end_i,
  input  logic           txn_valid_i,
  output logic           txn_ready_o,
  output logic           bus_own_o,
  output logic           agent_id_o
);
  localparam int unsigned SW = NAG + 4;

  logic [NAG-1:0] req_s;
  logic           prio_s;
  logic           stall_s;
  logic           init_s;
  logic           pissue_s;
  logic           init_evt;
  logic           stall_hold;
  logic           phase_hit;
  logic           lock_q;
  logic           fire;
  logic           own;
  logic           id_valid;
  logic           req_q;
  agent_id_t      agent_id;

  bag_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_n   ({req_n_i, prio_n_i, stall_n_i, init_n_i, peer_issue_n_i}),
    .q     ({req_s, prio_s, stall_s, init_s, pissue_s})
  );

  bag_stall_sampler #(.STALL_PERIOD(STALL_PERIOD)) u_stall (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_s    (stall_s),
    .stall_hold (stall_hold),
    .phase_hit  (phase_hit)
  );

  assign init_evt = init_s & init_obs_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lock_q <= 1'b0;
    else if (init_evt)    lock_q <= 1'b0;
    else if (lock_end_i)  lock_q <= 1'b0;
    else if (lock_start_i) lock_q <= 1'b1;
  end

  assign txn_ready_o = id_valid & f_may_issue(own, prio_s, lock_q, stall_hold);
  assign fire        = txn_valid_i & txn_ready_o;

  bag_arbiter u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_lines_n  (req_n_i),
    .req_s        (req_s),
    .pending      (txn_valid_i),
    .fire         (fire),
    .peer_issue_s (pissue_s),
    .init_evt     (init_evt),
    .agent_id     (agent_id),
    .id_valid     (id_valid),
    .own          (own),
    .req_q        (req_q)
  );

  assign req_n_o    = ~req_q;
  assign bus_own_o  = own;
  assign agent_id_o = agent_id;
endmodule

// File: rtl/bag_checker.sv
module bag_checker (
  input logic clk,
  input logic rst_n,
  input logic txn_ready,
  input logic own,
  input logic prio_s,
  input logic lock_q,
  input logic stall_hold,
  input logic phase_hit,
  input logic init_evt,
  input logic id_valid,
  input logic agent_id,
  input logic req_n
);
  p_ready_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    txn_ready |-> own);

  p_prio_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_s && !lock_q) |-> !txn_ready);

  p_stall_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_hold |-> !txn_ready);

  p_stall_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_hit |=> $stable(stall_hold));

  p_init_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> !lock_q);

  p_init_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_evt && id_valid) |=> (own == (agent_id == 1'b0)));

  p_init_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> req_n);

  p_id_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> (id_valid && $stable(agent_id)));
endmodule

bind bus_agent_gate bag_checker u_bag_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .txn_ready  (txn_ready_o),
  .own        (own),
  .prio_s     (prio_s),
  .lock_q     (lock_q),
  .stall_hold (stall_hold),
  .phase_hit  (phase_hit),
  .init_evt   (init_evt),
  .id_valid   (id_valid),
  .agent_id   (agent_id_o),
  .req_n      (req_n_o)
);

// File: tb/test_bus_agent_gate.sv
module test_bus_agent_gate;
  localparam int unsigned SP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req_n_i = 2'b11;
  logic       prio_n_i = 1'b1, stall_n_i = 1'b1, init_n_i = 1'b1, peer_issue_n_i = 1'b1;
  logic       init_obs_en_i = 1'b0, lock_start_i = 1'b0, lock_end_i = 1'b0, txn_valid_i = 1'b0;
  logic       req_n_o, txn_ready_o, bus_own_o, agent_id_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  bit lk = 1'b0;

  always #4 clk = ~clk;

  bus_agent_gate #(.STALL_PERIOD(SP)) i_bus_agent_gate (
    .clk(clk), .rst_n(rst_n), .req_n_i(req_n_i), .req_n_o(req_n_o),
    .prio_n_i(prio_n_i), .stall_n_i(stall_n_i), .init_n_i(init_n_i),
    .peer_issue_n_i(peer_issue_n_i), .init_obs_en_i(init_obs_en_i),
    .lock_start_i(lock_start_i), .lock_end_i(lock_end_i),
    .txn_valid_i(txn_valid_i), .txn_ready_o(txn_ready_o),
    .bus_own_o(bus_own_o), .agent_id_o(agent_id_o)
  );

  // expected issue permission, written from the requirements
  function automatic logic f_expect_ready(input logic own, input logic prio,
                                          input logic lock, input logic stall);
    if (!own)  return 1'b0;
    if (stall) return 1'b0;
    if (prio)  return lock;
    return 1'b1;
  endfunction

  // expected agent number for a pattern of active-low lines
  function automatic logic f_expect_id(input logic [1:0] lines_n);
    return (lines_n[0] == 1'b1) && (lines_n[1] == 1'b0);
  endfunction

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic pulse_lock(input bit st, input bit en);
    lock_start_i = st; lock_end_i = en;
    tick();
    lock_start_i = 1'b0; lock_end_i = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] lines_n);
    rst_n = 1'b0; req_n_i = lines_n;
    tick(2);
    rst_n = 1'b1;
    tick();
    req_n_i = 2'b11;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(2'b01);
    chk("R1 id from line 1", agent_id_o, 1);
    chk("R3 agent 0 owns after reset", bus_own_o, 0);
    chk("R2 no request at reset", req_n_o, 1);
    chk("R4 no ready without ownership", txn_ready_o, 0);

    txn_valid_i = 1'b1;
    tick();
    chk("R2 request driven", req_n_o, 0);
    tick();
    chk("R3 takes idle bus", bus_own_o, 1);
    chk("R4 ready as owner", txn_ready_o, 1);

    prio_n_i = 1'b0; tick();
    chk("R5 priority blocks", txn_ready_o, 0);
    prio_n_i = 1'b1; tick();
    chk("R5 priority released", txn_ready_o, 1);

    pulse_lock(1, 0);
    prio_n_i = 1'b0; tick();
    chk("R6 lock exempts priority", txn_ready_o, 1);
    pulse_lock(0, 1);
    chk("R6 lock end restores gating", txn_ready_o, 0);
    pulse_lock(1, 1);
    chk("R6 end wins over start", txn_ready_o, 0);
    prio_n_i = 1'b1; tick();

    stall_n_i = 1'b0; tick(SP + 1);
    chk("R7 stall blocks", txn_ready_o, 0);
    tick(3);
    chk("R7 stall held", txn_ready_o, 0);
    stall_n_i = 1'b1; tick(SP + 1);
    chk("R7 stall released", txn_ready_o, 1);

    pulse_lock(1, 0);
    prio_n_i = 1'b0; tick();
    chk("R6 locked under priority", txn_ready_o, 1);
    init_obs_en_i = 1'b1; init_n_i = 1'b0; tick();
    init_n_i = 1'b1; tick();
    chk("R8 init resets owner", bus_own_o, 0);
    chk("R8 init drops request", req_n_o, 1);
    tick(3);
    chk("R8 re-arbitrates", bus_own_o, 1);
    chk("R8 lock cleared", txn_ready_o, 0);
    prio_n_i = 1'b1; tick();
    chk("R8 resumes issuing", txn_ready_o, 1);

    pulse_lock(1, 0);
    prio_n_i = 1'b0;
    init_obs_en_i = 1'b0; init_n_i = 1'b0; tick();
    init_n_i = 1'b1; tick();
    chk("R9 owner kept", bus_own_o, 1);
    chk("R9 request kept", req_n_o, 0);
    tick(2);
    chk("R9 lock kept", txn_ready_o, 1);
    pulse_lock(0, 1);

    // init clear and lock start reach the lock flag together
    init_obs_en_i = 1'b1; init_n_i = 1'b0; tick();
    init_n_i = 1'b1; lock_start_i = 1'b1; tick();
    lock_start_i = 1'b0;
    tick(4);
    chk("R8 owner back after init", bus_own_o, 1);
    chk("R8 init beats lock start", txn_ready_o, 0);
    prio_n_i = 1'b1; init_obs_en_i = 1'b0; tick();

    // handoff on issue while the peer requests
    req_n_i[0] = 1'b0; tick(2);
    chk("R3 issue hands bus to peer", bus_own_o, 0);
    chk("R4 no ready after handoff", txn_ready_o, 0);
    tick(3);
    chk("R3 peer keeps bus", bus_own_o, 0);
    peer_issue_n_i = 1'b0; tick();
    peer_issue_n_i = 1'b1; tick();
    chk("R3 peer issue returns bus", bus_own_o, 1);
    req_n_i[0] = 1'b1; tick(5);
    chk("R3 owner with idle peer", bus_own_o, 1);

    // idle owner yields
    txn_valid_i = 1'b0; req_n_i[0] = 1'b0; tick(2);
    chk("R3 idle owner yields", bus_own_o, 0);
    chk("R2 request withdrawn", req_n_o, 1);
    txn_valid_i = 1'b1; tick(4);
    chk("R3 no take while peer holds", bus_own_o, 0);
    req_n_i[0] = 1'b1; tick(3);
    chk("R3 takes after peer release", bus_own_o, 1);

    // constrained random gating
    lk = 1'b0;
    for (int i = 0; i < 40; i++) begin
      int op;
      logic pr, st;
      op = int'($urandom % 3);
      pr = logic'($urandom % 2);
      st = ($urandom % 3) == 0;
      if (op == 1) begin pulse_lock(1, 0); lk = 1'b1; end
      else if (op == 2) begin pulse_lock(0, 1); lk = 1'b0; end
      prio_n_i = ~pr; stall_n_i = ~st;
      tick(SP + 2);
      chk("R4 R5 R6 R7 random gating", txn_ready_o,
          f_expect_ready(1'b1, pr, lk, st));
    end
    prio_n_i = 1'b1; stall_n_i = 1'b1; txn_valid_i = 1'b0;

    for (int k = 0; k < 3; k++) begin
      logic [1:0] pat;
      pat = (k == 0) ? 2'b10 : ((k == 1) ? 2'b11 : 2'b00);
      do_reset(pat);
      chk("R1 id pattern", agent_id_o, f_expect_id(pat));
      chk("R3 agent 0 owns at start", bus_own_o, !f_expect_id(pat));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule